// File: doc/BRIEF.md
# Unit-Stride Vector Beat Coalescer

This block serves one lane of a multi-lane vector machine. It takes a unit-stride vector memory command and turns it into a stream of 128-bit memory beat requests. A command carries a base byte address, a vector length, an element size, this lane's index, the lane count as a power of two, the lane stride in strips, a load/store flag and one predicate bit per element.

Vector elements are dealt out to the lanes in chunks of `(stride+1)*8` consecutive elements, round-robin. The block walks only the elements its lane owns. It closes a segment at each chunk boundary and jumps over the chunks that belong to the other lanes. Within a segment it packs as many adjacent elements as fit in one aligned 16-byte beat. For each beat it reports the aligned address, a byte mask, the index of the first element and the element count.

Bases that are not 16-byte aligned and lengths that are not a multiple of the packing density both produce partial beats. Neighbouring lanes can request the same beat at a chunk boundary. Those duplicates are issued and not filtered out.

Top module: `vec_unit_coalescer`

## Requirements
- R1: After reset, and after any reset in the middle of a command, `cmd_ready_o` is 1 and `beat_valid_o` is 0.
- R2: With chunk size C = (cmd_stride_i+1)*8 and L = 2^cmd_lanes_log2_i, the lane owns element i exactly when floor(i/C) mod L equals cmd_lane_i (cmd_lane_i < L). Only owned elements below the vector length are covered by beats, each exactly once, in ascending order.
- R3: Element i is at byte address base + i*S. Here S is 1, 2, 4 or 8 for `cmd_esz_i` values 0, 1, 2 and 3, and the base is a multiple of S. `beat_addr_o` is that address rounded down to a multiple of 16.
- R4: A beat holds the longest run of consecutive owned elements, starting at `beat_elem_o`, that share one 16-byte block. `beat_cnt_o` gives the length of that run. With a single lane, chunk boundaries do not split beats.
- R5: For loads (`cmd_store_i`=0), bit b of `beat_mask_o` is set exactly when byte b of the beat belongs to an element that the beat covers. Bit 0 is the lowest address.
- R6: For stores, the bytes of a covered element i are set only if bit i of `cmd_pred_i` is 1. A beat whose covered elements are all false is still issued, with a zero mask.
- R7: `beat_done_o` is 1 on the lane's final beat of the command and 0 on every other beat. After that beat is accepted, the block is idle in the next cycle.
- R8: A command is accepted only while `cmd_ready_o` is 1, and `cmd_ready_o` is 0 while a command has beats left to issue.
- R9: A command for which the lane owns no element is accepted and produces no beat.
- R10: While `beat_valid_o` is 1 and `beat_ready_i` is 0, all beat outputs hold their values into the next cycle.
- R11: At a chunk boundary with an unaligned base, two lanes may both issue the beat with the same address. Each issues it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken this cycle if offered |
| cmd_base_i | input | ADDR_W | Byte address of element 0 |
| cmd_vlen_i | input | VL_W | Vector length in elements (at most MAX_VL) |
| cmd_esz_i | input | 2 | Element size code (0:1B, 1:2B, 2:4B, 3:8B) |
| cmd_store_i | input | 1 | 1 for store (predicates shape the mask) |
| cmd_pred_i | input | MAX_VL | Per-element predicate, bit i for element i |
| cmd_lane_i | input | MAX_LANES_LOG2 | Index of this lane |
| cmd_lanes_log2_i | input | LL_W | log2 of the lane count |
| cmd_stride_i | input | STRIDE_W | Lane stride in strips, minus one |
| beat_valid_o | output | 1 | Beat request valid |
| beat_ready_i | input | 1 | Beat request taken |
| beat_addr_o | output | ADDR_W | 16-byte aligned beat address |
| beat_mask_o | output | 16 | Byte enables of the beat |
| beat_elem_o | output | IDX_W | Index of first element in the beat |
| beat_cnt_o | output | CNT_W | Number of elements in the beat |
| beat_done_o | output | 1 | Final beat of the command |

## Verification
The bench checks each beat against an independent model that enumerates elements by division and modulo. The cases cover unaligned bases that give partial first and last beats, byte elements that cross chunk boundaries with a single lane (a design that split there would issue extra short beats), and lanes whose next chunk lies past the vector length (a design that got this wrong would issue beats past the end or never raise done). Other cases target a lane with no elements, which must not hang or emit a stray beat, and a store beat with all predicates false, which must still be issued with a zero mask. Duplicate beats at the boundary between lanes 0 and 1 are checked by address on both lanes. Backpressure and a command offered while the block is busy are applied to confirm that outputs hold and that no second command is taken early.

// File: rtl/vec_coal_pkg.sv
package vec_coal_pkg;
  localparam int BEAT_BYTES  = 16;
  localparam int BEAT_OFF_W  = 4;
  localparam int STRIP_LOG2  = 3;
  localparam int CNT_W       = $clog2(BEAT_BYTES + 1);

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;
endpackage

// File: rtl/vec_coal_seg_track.sv
module vec_coal_seg_track #(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] first_i,
  input  logic [IDX_W-1:0] chunk_start_i,
  input  logic             adv_i,
  input  logic             seg_end_i,
  input  logic [IDX_W-1:0] next_elem_i,
  input  logic [IDX_W-1:0] step_i,
  input  logic [IDX_W-1:0] chunk_i,
  output logic [IDX_W-1:0] elem_o,
  output logic [IDX_W-1:0] chunk_left_o
);
  logic [IDX_W-1:0] elem_q, left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_q <= '0;
      left_q <= '0;
    end else if (start_i) begin
      elem_q <= first_i;
      left_q <= chunk_start_i;
    end else if (adv_i) begin
      elem_q <= next_elem_i;
      // reload at a segment jump, otherwise consume the chunk
      left_q <= seg_end_i ? chunk_i : left_q - step_i;
    end
  end

  assign elem_o       = elem_q;
  assign chunk_left_o = left_q;
endmodule

// File: rtl/vec_coal_beat_pack.sv
module vec_coal_beat_pack
  import vec_coal_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int MAX_VL = 64
) (
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [IDX_W-1:0]      elem_i,
  input  logic [IDX_W-1:0]      vlen_i,
  input  logic [IDX_W-1:0]      chunk_left_i,
  input  logic [IDX_W-1:0]      gap_i,
  input  logic                  multi_i,
  input  esz_e                  esz_i,
  input  logic                  store_i,
  input  logic [MAX_VL-1:0]     pred_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [BEAT_BYTES-1:0] mask_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [IDX_W-1:0]      step_o,
  output logic                  seg_end_o,
  output logic [IDX_W-1:0]      next_elem_o,
  output logic                  last_o
);
  localparam int PI_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  logic [ADDR_W-1:0]     eaddr;
  logic [BEAT_OFF_W-1:0] off;
  logic [CNT_W-1:0]      nfit, span;
  logic [IDX_W-1:0]      remain, n_vl, n_idx;

  always_comb begin
    eaddr  = base_i + (ADDR_W'(elem_i) << esz_i);
    off    = eaddr[BEAT_OFF_W-1:0];
    nfit   = (CNT_W'(BEAT_BYTES) - CNT_W'(off)) >> esz_i;
    remain = vlen_i - elem_i;
    n_vl   = (IDX_W'(nfit) < remain) ? IDX_W'(nfit) : remain;
    // chunk boundaries only matter when other lanes own the gap
    n_idx  = (multi_i && (chunk_left_i < n_vl)) ? chunk_left_i : n_vl;
    span   = CNT_W'(n_idx) << esz_i;
  end

  assign addr_o      = {eaddr[ADDR_W-1:BEAT_OFF_W], {BEAT_OFF_W{1'b0}}};
  assign cnt_o       = CNT_W'(n_idx);
  assign step_o      = n_idx;
  assign seg_end_o   = multi_i && (n_idx == chunk_left_i);
  assign next_elem_o = elem_i + n_idx + (seg_end_o ? gap_i : '0);
  assign last_o      = next_elem_o >= vlen_i;

  logic [CNT_W-1:0] rel, kk;
  logic [IDX_W-1:0] pidx;
  logic             hit;

  always_comb begin
    mask_o = '0;
    rel    = '0;
    kk     = '0;
    pidx   = '0;
    hit    = 1'b0;
    for (int b = 0; b < BEAT_BYTES; b++) begin
      rel  = CNT_W'(b) - CNT_W'(off);
      kk   = rel >> esz_i;
      pidx = elem_i + IDX_W'(kk);
      hit  = (CNT_W'(b) >= CNT_W'(off)) && (rel < span);
      mask_o[b] = hit && (!store_i || pred_i[pidx[PI_W-1:0]]);
    end
  end
endmodule

// File: rtl/vec_unit_coalescer.sv
module vec_unit_coalescer
  import vec_coal_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int MAX_VL         = 64,
  parameter int MAX_LANES_LOG2 = 3,
  parameter int STRIDE_W       = 3,
  parameter int IDX_W          = 16,
  localparam int VL_W          = $clog2(MAX_VL + 1),
  localparam int LL_W          = $clog2(MAX_LANES_LOG2 + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  output logic                      cmd_ready_o,
  input  logic [ADDR_W-1:0]         cmd_base_i,
  input  logic [VL_W-1:0]           cmd_vlen_i,
  input  logic [1:0]                cmd_esz_i,
  input  logic                      cmd_store_i,
  input  logic [MAX_VL-1:0]         cmd_pred_i,
  input  logic [MAX_LANES_LOG2-1:0] cmd_lane_i,
  input  logic [LL_W-1:0]           cmd_lanes_log2_i,
  input  logic [STRIDE_W-1:0]       cmd_stride_i,
  output logic                      beat_valid_o,
  input  logic                      beat_ready_i,
  output logic [ADDR_W-1:0]         beat_addr_o,
  output logic [BEAT_BYTES-1:0]     beat_mask_o,
  output logic [IDX_W-1:0]          beat_elem_o,
  output logic [CNT_W-1:0]          beat_cnt_o,
  output logic                      beat_done_o
);
  logic              busy_q, multi_q, store_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  vlen_q, chunk_q, gap_q;
  logic [MAX_VL-1:0] pred_q;
  esz_e              esz_q;

  logic [IDX_W-1:0] chunk_in, first_in, gap_in, vlen_in;
  logic             accept, fire;

  assign chunk_in = (IDX_W'(cmd_stride_i) << STRIP_LOG2) + (IDX_W'(1) << STRIP_LOG2);
  assign first_in = IDX_W'(cmd_lane_i) * chunk_in;
  assign gap_in   = (chunk_in << cmd_lanes_log2_i) - chunk_in;
  assign vlen_in  = IDX_W'(cmd_vlen_i);
  assign accept   = cmd_valid_i && !busy_q;

  logic [IDX_W-1:0] elem, chunk_left, next_elem, step;
  logic             seg_end, last;

  assign fire = busy_q && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      multi_q <= 1'b0;
      store_q <= 1'b0;
      base_q  <= '0;
      vlen_q  <= '0;
      chunk_q <= '0;
      gap_q   <= '0;
      pred_q  <= '0;
      esz_q   <= ESZ_8;
    end else if (accept) begin
      busy_q  <= first_in < vlen_in;
      multi_q <= cmd_lanes_log2_i != '0;
      store_q <= cmd_store_i;
      base_q  <= cmd_base_i;
      vlen_q  <= vlen_in;
      chunk_q <= chunk_in;
      gap_q   <= gap_in;
      pred_q  <= cmd_pred_i;
      esz_q   <= esz_e'(cmd_esz_i);
    end else if (fire && last) begin
      busy_q <= 1'b0;
    end
  end

  vec_coal_seg_track #(.IDX_W(IDX_W)) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .first_i       (first_in),
    .chunk_start_i (chunk_in),
    .adv_i         (fire),
    .seg_end_i     (seg_end),
    .next_elem_i   (next_elem),
    .step_i        (step),
    .chunk_i       (chunk_q),
    .elem_o        (elem),
    .chunk_left_o  (chunk_left)
  );

  vec_coal_beat_pack #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .MAX_VL (MAX_VL)
  ) u_pack (
    .base_i       (base_q),
    .elem_i       (elem),
    .vlen_i       (vlen_q),
    .chunk_left_i (chunk_left),
    .gap_i        (gap_q),
    .multi_i      (multi_q),
    .esz_i        (esz_q),
    .store_i      (store_q),
    .pred_i       (pred_q),
    .addr_o       (beat_addr_o),
    .mask_o       (beat_mask_o),
    .cnt_o        (beat_cnt_o),
    .step_o       (step),
    .seg_end_o    (seg_end),
    .next_elem_o  (next_elem),
    .last_o       (last)
  );

  assign cmd_ready_o  = !busy_q;
  assign beat_valid_o = busy_q;
  assign beat_elem_o  = elem;
  assign beat_done_o  = busy_q && last;
endmodule

// File: rtl/vec_unit_coalescer_chk.sv
module vec_unit_coalescer_chk
  import vec_coal_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int MAX_VL         = 64,
  parameter int MAX_LANES_LOG2 = 3,
  parameter int STRIDE_W       = 3,
  parameter int IDX_W          = 16,
  localparam int VL_W          = $clog2(MAX_VL + 1),
  localparam int LL_W          = $clog2(MAX_LANES_LOG2 + 1)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_valid_i,
  input logic                      cmd_ready_o,
  input logic [ADDR_W-1:0]         cmd_base_i,
  input logic [VL_W-1:0]           cmd_vlen_i,
  input logic [1:0]                cmd_esz_i,
  input logic                      cmd_store_i,
  input logic [MAX_VL-1:0]         cmd_pred_i,
  input logic [MAX_LANES_LOG2-1:0] cmd_lane_i,
  input logic [LL_W-1:0]           cmd_lanes_log2_i,
  input logic [STRIDE_W-1:0]       cmd_stride_i,
  input logic                      beat_valid_o,
  input logic                      beat_ready_i,
  input logic [ADDR_W-1:0]         beat_addr_o,
  input logic [BEAT_BYTES-1:0]     beat_mask_o,
  input logic [IDX_W-1:0]          beat_elem_o,
  input logic [CNT_W-1:0]          beat_cnt_o,
  input logic                      beat_done_o
);
  a_r3_beat_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_addr_o[BEAT_OFF_W-1:0] == '0));

  a_r8_busy_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !cmd_ready_o);

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_cnt_o != '0 && beat_cnt_o <= CNT_W'(BEAT_BYTES)));

  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o)
      && $stable(beat_mask_o) && $stable(beat_elem_o) && $stable(beat_cnt_o)
      && $stable(beat_done_o)));

  a_r7_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && beat_done_o) |=> (cmd_ready_o && !beat_valid_o));

  a_r7_not_done_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && !beat_done_o) |=> beat_valid_o);
endmodule

bind vec_unit_coalescer vec_unit_coalescer_chk #(
  .ADDR_W         (ADDR_W),
  .MAX_VL         (MAX_VL),
  .MAX_LANES_LOG2 (MAX_LANES_LOG2),
  .STRIDE_W       (STRIDE_W),
  .IDX_W          (IDX_W)
) u_chk (.*);

// File: tb/vec_unit_coalescer_tb_top.sv
module vec_unit_coalescer_tb_top;
  localparam int ADDR_W = 32;
  localparam int MAX_VL = 64;
  localparam int MLL    = 3;
  localparam int SW     = 3;
  localparam int IDX_W  = 16;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int LL_W   = $clog2(MLL + 1);
  localparam int NT     = 10;

  typedef struct packed {
    logic [31:0] base;
    logic [6:0]  vlen;
    logic [1:0]  esz;
    logic        store;
    logic [63:0] pred;
    logic [2:0]  lane;
    logic [1:0]  ll;
    logic [2:0]  stride;
    logic [7:0]  nbeats;
  } vec_t;

  localparam vec_t TAB [NT] = '{
    '{32'h100, 7'd16, 2'd2, 1'b0, 64'h0,  3'd0, 2'd0, 3'd0, 8'd4},
    '{32'h104, 7'd16, 2'd2, 1'b0, 64'h0,  3'd0, 2'd0, 3'd0, 8'd5},
    '{32'h104, 7'd40, 2'd2, 1'b0, 64'h0,  3'd1, 2'd2, 3'd0, 8'd3},
    '{32'h104, 7'd40, 2'd2, 1'b0, 64'h0,  3'd0, 2'd2, 3'd0, 8'd6},
    '{32'h200, 7'd5,  2'd3, 1'b0, 64'h0,  3'd0, 2'd0, 3'd0, 8'd3},
    '{32'h003, 7'd20, 2'd0, 1'b0, 64'h0,  3'd0, 2'd0, 3'd0, 8'd2},
    '{32'h01E, 7'd10, 2'd1, 1'b0, 64'h0,  3'd1, 2'd1, 3'd1, 8'd0},
    '{32'h100, 7'd8,  2'd2, 1'b1, 64'hB5, 3'd0, 2'd0, 3'd0, 8'd2},
    '{32'h100, 7'd4,  2'd2, 1'b1, 64'h0,  3'd0, 2'd0, 3'd0, 8'd1},
    '{32'h007, 7'd64, 2'd0, 1'b0, 64'h0,  3'd3, 2'd2, 3'd1, 8'd2}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [ADDR_W-1:0] cmd_base_i = '0;
  logic [VL_W-1:0] cmd_vlen_i = '0;
  logic [1:0] cmd_esz_i = '0;
  logic cmd_store_i = 1'b0;
  logic [MAX_VL-1:0] cmd_pred_i = '0;
  logic [MLL-1:0] cmd_lane_i = '0;
  logic [LL_W-1:0] cmd_lanes_log2_i = '0;
  logic [SW-1:0] cmd_stride_i = '0;
  logic beat_valid_o;
  logic beat_ready_i = 1'b1;
  logic [ADDR_W-1:0] beat_addr_o;
  logic [15:0] beat_mask_o;
  logic [IDX_W-1:0] beat_elem_o;
  logic [4:0] beat_cnt_o;
  logic beat_done_o;

  always #5 clk_i = ~clk_i;

  vec_unit_coalescer dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] exp_addr [64];
  logic [15:0] exp_mask [64];
  int          exp_elem [64];
  int          exp_cnt  [64];
  int          exp_n;
  logic [31:0] got_addr [64];
  logic [15:0] got_mask [64];
  int          got_cnt  [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // independent reference: enumerate elements, ownership by div/mod
  task automatic model(input vec_t v);
    int c, l, last_i;
    logic [31:0] a, ba;
    c = (int'(v.stride) + 1) * 8;
    l = 1 << v.ll;
    exp_n = 0;
    last_i = -2;
    for (int i = 0; i < int'(v.vlen); i++) begin
      if (((i / c) % l) == int'(v.lane)) begin
        a  = v.base + (32'(i) << v.esz);
        ba = a & 32'hFFFF_FFF0;
        if (exp_n > 0 && last_i == i - 1 && ba == exp_addr[exp_n-1]) begin
          exp_cnt[exp_n-1]++;
        end else begin
          exp_addr[exp_n] = ba;
          exp_mask[exp_n] = '0;
          exp_elem[exp_n] = i;
          exp_cnt[exp_n]  = 1;
          exp_n++;
        end
        for (int j = 0; j < (1 << v.esz); j++)
          if (!v.store || v.pred[i]) exp_mask[exp_n-1][int'(a[3:0]) + j] = 1'b1;
        last_i = i;
      end
    end
  endtask

  task automatic drive_cmd(input vec_t v);
    cmd_base_i       = v.base;
    cmd_vlen_i       = v.vlen;
    cmd_esz_i        = v.esz;
    cmd_store_i      = v.store;
    cmd_pred_i       = v.pred;
    cmd_lane_i       = v.lane;
    cmd_lanes_log2_i = v.ll;
    cmd_stride_i     = v.stride;
  endtask

  task automatic run(input int t);
    vec_t v;
    int nb, cyc;
    bit stall, rdy;
    logic [31:0] s_addr; logic [15:0] s_mask; logic [IDX_W-1:0] s_elem;
    logic [4:0] s_cnt; logic s_done;
    v = TAB[t];
    model(v);
    chk(exp_n == int'(v.nbeats), "R2", $sformatf("model beats t%0d", t), exp_n, v.nbeats);
    @(negedge clk_i);
    drive_cmd(v);
    cmd_valid_i = 1'b1;
    chk(cmd_ready_o == 1'b1, "R8", "idle ready", cmd_ready_o, 1);
    @(negedge clk_i);
    if (exp_n > 0) begin
      cmd_base_i = v.base ^ 32'h1000;   // interfering command while busy
      cmd_valid_i = 1'b1;
    end else cmd_valid_i = 1'b0;
    nb = 0; cyc = 0; stall = 0;
    s_addr = '0; s_mask = '0; s_elem = '0; s_cnt = '0; s_done = 0;
    while (nb < exp_n && cyc < 400) begin
      if (stall)
        chk(beat_valid_o && beat_addr_o == s_addr && beat_mask_o == s_mask &&
            beat_elem_o == s_elem && beat_cnt_o == s_cnt && beat_done_o == s_done,
            "R10", "hold on stall", beat_addr_o, s_addr);
      rdy = (t % 2 == 1) ? ((cyc % 3) != 1) : 1'b1;
      beat_ready_i = rdy;
      stall = 0;
      if (beat_valid_o) begin
        chk(cmd_ready_o == 1'b0, "R8", "ready low while busy", cmd_ready_o, 0);
        if (rdy) begin
          if (nb == exp_n - 1) cmd_valid_i = 1'b0;
          chk(beat_addr_o == exp_addr[nb], "R3", $sformatf("addr t%0d b%0d", t, nb), beat_addr_o, exp_addr[nb]);
          chk(beat_mask_o == exp_mask[nb], v.store ? "R6" : "R5", $sformatf("mask t%0d b%0d", t, nb), beat_mask_o, exp_mask[nb]);
          chk(int'(beat_elem_o) == exp_elem[nb], "R2", $sformatf("elem t%0d b%0d", t, nb), beat_elem_o, exp_elem[nb]);
          chk(int'(beat_cnt_o) == exp_cnt[nb], "R4", $sformatf("cnt t%0d b%0d", t, nb), beat_cnt_o, exp_cnt[nb]);
          chk(beat_done_o == (nb == exp_n - 1), "R7", $sformatf("done t%0d b%0d", t, nb), beat_done_o, nb == exp_n - 1);
          got_addr[nb] = beat_addr_o;
          got_mask[nb] = beat_mask_o;
          got_cnt[nb]  = int'(beat_cnt_o);
          nb++;
        end else begin
          stall = 1;
          s_addr = beat_addr_o; s_mask = beat_mask_o; s_elem = beat_elem_o;
          s_cnt = beat_cnt_o; s_done = beat_done_o;
        end
      end
      @(negedge clk_i);
      cyc++;
    end
    cmd_valid_i = 1'b0;
    beat_ready_i = 1'b1;
    chk(nb == exp_n, "R2", $sformatf("beat count t%0d", t), nb, exp_n);
    chk(!beat_valid_o && cmd_ready_o, (exp_n == 0) ? "R9" : "R7", $sformatf("idle after t%0d", t),
        {beat_valid_o, cmd_ready_o}, 2'b01);
    @(negedge clk_i);
    chk(!beat_valid_o, "R9", "no stray beat", beat_valid_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] t2_addr0;
    t2_addr0 = '0;
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1 && beat_valid_o == 1'b0, "R1", "reset state",
        {cmd_ready_o, beat_valid_o}, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1 && beat_valid_o == 1'b0, "R1", "after release",
        {cmd_ready_o, beat_valid_o}, 2'b10);

    for (int t = 0; t < NT; t++) begin
      run(t);
      case (t)
        1: begin
          chk(got_mask[0] == 16'hFFF0, "R5", "partial first beat", got_mask[0], 16'hFFF0);
          chk(got_mask[4] == 16'h000F, "R5", "partial last beat", got_mask[4], 16'h000F);
        end
        2: t2_addr0 = got_addr[0];
        3: begin
          chk(t2_addr0 == 32'h120, "R11", "lane1 first beat", t2_addr0, 32'h120);
          chk(got_addr[2] == 32'h120, "R11", "lane0 duplicate beat", got_addr[2], 32'h120);
        end
        5: chk(got_cnt[0] == 13, "R4", "single lane crosses chunk", got_cnt[0], 13);
        7: begin
          chk(got_mask[0] == 16'h0F0F, "R6", "store mask b0", got_mask[0], 16'h0F0F);
          chk(got_mask[1] == 16'hF0FF, "R6", "store mask b1", got_mask[1], 16'hF0FF);
        end
        8: chk(got_mask[0] == 16'h0000, "R6", "all-false beat issued", got_mask[0], 0);
        default: ;
      endcase
    end

    // reset in the middle of a command
    @(negedge clk_i);
    drive_cmd(TAB[0]);
    cmd_valid_i = 1'b1;
    beat_ready_i = 1'b0;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(beat_valid_o == 1'b1, "R8", "busy before reset", beat_valid_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(cmd_ready_o == 1'b1 && beat_valid_o == 1'b0, "R1", "mid-command reset",
        {cmd_ready_o, beat_valid_o}, 2'b10);
    @(negedge clk_i);
    rst_ni = 1'b1;
    beat_ready_i = 1'b1;
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R1", "idle after reset", beat_valid_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule